// File: doc/BRIEF.md
# Serial Pattern Receive Checker

This block checks a serial bit stream against a reference pattern that it builds on its own. The reference is either a pseudorandom sequence from the polynomial x^15 + x^14 + 1, or a repeating word whose period is set by a four-bit length code. While it is out of lock, the block loads its pattern history from the received bits and looks for a long run of bits that the history predicts correctly. Once it has locked, the history runs on by itself. Each received bit is then compared with the predicted bit. The block counts the bits and the mismatches, and it drops lock when mismatches come too close together.

Three sticky status flags record three conditions: a counter overflow, a detected bit error, and a change of lock state in either direction. Each flag has its own enable. The single interrupt line is high while any enabled flag is set. The flags are cleared by a one-cycle clear pulse. The counters run from reset and are not cleared by that pulse.

Top module: `bert_rx_checker`

## Requirements
- R1: With `pat_sel`=0 the predicted bit is the bit received 17+`len_code` bits earlier, so a stream with period 17+code locks for every code 0..15. With `pat_sel`=1 the predicted bit is x[n-15] XOR x[n-14].
- R2: While out of lock, each received bit is shifted into the history. Lock is declared at the edge of the 32nd consecutive correctly predicted bit, and not before.
- R3: In lock, the 6th mismatch within any 64 consecutive received bits drops lock at the edge of that bit. Mismatches spaced 13 bits apart never drop lock.
- R4: A bit taken with `bit_en`=1 while in lock adds 1 to `bit_count`, and also adds 1 to `err_count` if it mismatches. Bits taken out of lock, and cycles with `bit_en`=0, change neither counter.
- R5: Both counters saturate at all-ones. An increment attempted at all-ones sets `flags[0]` (overflow).
- R6: A counted mismatch sets `flags[1]` (bit error). Any change of `in_sync` sets `flags[2]` (lock change) at the same edge.
- R7: Flags stay set until a cycle with `flag_clr`=1. If a set event falls in the same cycle as the clear, the flag ends up set.
- R8: `irq` is high exactly when some i has both `flags[i]` and `int_en[i]` set (bit 0 overflow, bit 1 error, bit 2 lock change). It is low when `int_en` is zero.
- R9: In lock the reference runs on by itself, so one flipped bit adds exactly one error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Takes `rx_bit` in this cycle |
| rx_bit | input | 1 | Received serial bit |
| pat_sel | input | 1 | 0 = repeating word, 1 = pseudorandom |
| len_code | input | 4 | Repeat period is 17 + code |
| int_en | input | 3 | Per-flag interrupt enables |
| flag_clr | input | 1 | Clears the sticky flags |
| in_sync | output | 1 | Lock status |
| bit_count | output | BIT_W | Saturating count of bits checked |
| err_count | output | ERR_W | Saturating count of mismatches |
| flags | output | 3 | Sticky overflow, error and lock-change flags |
| irq | output | 1 | Masked interrupt |

## Verification
Two events can coincide in a single cycle, and the bench provokes both. In the first case, the sixth close mismatch is arranged to also be the sixteenth counted error on a four-bit error counter, so the same edge must drop lock, saturate the counter and set both the overflow flag and the lock-change flag. In the second case, a flipped bit is sent in the same cycle as the flag clear, and the bench requires the error flag to be set afterwards and the error count to have gone up by exactly one.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
   localparam int NUM_FLAGS = 3;
   typedef enum int {
      FLG_OVF  = 0,
      FLG_ERR  = 1,
      FLG_SYNC = 2
   } flag_idx_e;
endpackage

// File: rtl/bert_rx_ref.sv
module bert_rx_ref #(
   parameter int REF_W   = 32,
   parameter int REP_MIN = 17,
   parameter int TAP_A   = 15,
   parameter int TAP_B   = 14,
   parameter bit REP_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       rx_bit,
   input  logic       locked,
   input  logic       pat_sel,
   input  logic [3:0] len_code,
   output logic       pred
);
   localparam int REP_MAX = REP_MIN + 15;

   if (REP_EN && REP_MAX > REF_W) begin : g_bad_len
      $error("history too short for longest period");
   end
   if (TAP_A > REF_W || TAP_B > REF_W || TAP_A < 1 || TAP_B < 1) begin : g_bad_tap
      $error("tap outside history");
   end

   logic [REF_W-1:0] hist_q;
   logic             prbs_bit;

   assign prbs_bit = hist_q[TAP_A-1] ^ hist_q[TAP_B-1];

   if (REP_EN) begin : g_rep
      logic rep_bit;
      assign rep_bit = hist_q[int'(len_code) + REP_MIN - 1];
      assign pred    = pat_sel ? prbs_bit : rep_bit;
   end else begin : g_prbs_only
      logic unused_cfg;
      assign unused_cfg = pat_sel ^ (^len_code);
      assign pred       = prbs_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (bit_en) begin
         hist_q <= {hist_q[REF_W-2:0], locked ? pred : rx_bit};
      end
   end

   AST_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && locked) |=> (hist_q[0] == $past(pred)));   // R9
   AST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !locked) |=> (hist_q[0] == $past(rx_bit)));  // R2
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync #(
   parameter int SYNC_BITS = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERR  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic match,
   output logic locked,
   output logic err_evt,
   output logic chg_evt
);
   localparam int RW = $clog2(SYNC_BITS + 1);
   localparam int CW = $clog2(WIN + 1);

   if (SYNC_BITS < 2 || WIN < 2 || LOSS_ERR < 1 || LOSS_ERR > WIN) begin : g_bad_cfg
      $error("bad lock parameters");
   end

   logic [RW-1:0]  run_q;
   logic [WIN-1:0] win_q;
   logic [CW-1:0]  wcnt_q, wcnt_nx;
   logic           gain, lose;

   assign err_evt = bit_en && locked && !match;
   assign wcnt_nx = wcnt_q + CW'(err_evt) - CW'(win_q[WIN-1]);
   assign gain    = bit_en && !locked && match && (run_q == RW'(SYNC_BITS - 1));
   assign lose    = bit_en && locked && (wcnt_nx >= CW'(LOSS_ERR));
   assign chg_evt = gain || lose;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         run_q  <= '0;
         win_q  <= '0;
         wcnt_q <= '0;
      end else if (bit_en) begin
         if (!locked) begin
            if (gain) begin
               locked <= 1'b1;
               run_q  <= '0;
            end else if (match) begin
               run_q <= run_q + 1'b1;
            end else begin
               run_q <= '0;
            end
         end else if (lose) begin
            locked <= 1'b0;
            win_q  <= '0;
            wcnt_q <= '0;
         end else begin
            win_q  <= {win_q[WIN-2:0], err_evt};
            wcnt_q <= wcnt_nx;
         end
      end
   end

   AST_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(bit_en && match));   // R2
   AST_FALL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(err_evt));   // R3
   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (wcnt_q < CW'(LOSS_ERR)));   // R3
endmodule

// File: rtl/bert_rx_satcnt.sv
module bert_rx_satcnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         ovf_evt
);
   if (W < 2) begin : g_bad_w
      $error("counter width too small");
   end

   logic at_max;
   assign at_max  = &cnt;
   assign ovf_evt = inc && at_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc && !at_max) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt) |=> (&cnt));   // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));   // R4
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
   import bert_rx_pkg::*;
#(
   parameter int BIT_W     = 32,
   parameter int ERR_W     = 32,
   parameter int SYNC_BITS = 32,
   parameter int WIN       = 64,
   parameter int LOSS_ERR  = 6,
   parameter bit REP_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 rx_bit,
   input  logic                 pat_sel,
   input  logic [3:0]           len_code,
   input  logic [NUM_FLAGS-1:0] int_en,
   input  logic                 flag_clr,
   output logic                 in_sync,
   output logic [BIT_W-1:0]     bit_count,
   output logic [ERR_W-1:0]     err_count,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 irq
);
   logic pred, match, err_evt, chg_evt, bit_inc, bit_ovf, err_ovf;
   logic [NUM_FLAGS-1:0] set_vec;

   assign match   = (rx_bit == pred);
   assign bit_inc = bit_en && in_sync;

   bert_rx_ref #(.REF_W(32), .REP_MIN(17), .TAP_A(15), .TAP_B(14), .REP_EN(REP_EN)) u_ref (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .locked(in_sync),
      .pat_sel(pat_sel), .len_code(len_code), .pred(pred));

   bert_rx_sync #(.SYNC_BITS(SYNC_BITS), .WIN(WIN), .LOSS_ERR(LOSS_ERR)) u_sync (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .match(match),
      .locked(in_sync), .err_evt(err_evt), .chg_evt(chg_evt));

   bert_rx_satcnt #(.W(BIT_W)) u_bits (
      .clk(clk), .rst_n(rst_n), .inc(bit_inc), .cnt(bit_count), .ovf_evt(bit_ovf));

   bert_rx_satcnt #(.W(ERR_W)) u_errs (
      .clk(clk), .rst_n(rst_n), .inc(err_evt), .cnt(err_count), .ovf_evt(err_ovf));

   always_comb begin
      set_vec           = '0;
      set_vec[FLG_OVF]  = bit_ovf || err_ovf;
      set_vec[FLG_ERR]  = err_evt;
      set_vec[FLG_SYNC] = chg_evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flag_clr ? '0 : flags) | set_vec;
      end
   end

   assign irq = |(flags & int_en);

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FLG_ERR] && !flag_clr) |=> flags[FLG_ERR]);   // R7
   AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> flags[FLG_ERR]);   // R6
   AST_SYNC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync != $past(in_sync)) |-> flags[FLG_SYNC]);   // R6
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == '0) |-> !irq);   // R8
endmodule

// File: tb/bert_rx_checker_test.sv
module bert_rx_checker_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_W = 10;
   localparam int ERR_W = 4;
   localparam logic [BIT_W-1:0] BIT_MAX = '1;
   localparam logic [31:0] REP_WORD = 32'hB38F_0E5D;

   logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b0, pat_sel = 1'b1, flag_clr = 1'b0;
   logic [3:0] len_code = 4'd0;
   logic [2:0] int_en = 3'b000;
   logic in_sync, irq;
   logic [BIT_W-1:0] bit_count;
   logic [ERR_W-1:0] err_count;
   logic [2:0] flags;

   int n_checks = 0, n_errors = 0;
   int e_bits = 0, e_errs = 0;
   bit e_sync = 1'b0;
   logic [14:0] gen = 15'h1A5C;

   always #(CLK_PERIOD/2) clk = ~clk;

   bert_rx_checker #(.BIT_W(BIT_W), .ERR_W(ERR_W)) uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .pat_sel(pat_sel),
      .len_code(len_code), .int_en(int_en), .flag_clr(flag_clr), .in_sync(in_sync),
      .bit_count(bit_count), .err_count(err_count), .flags(flags), .irq(irq));

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one cycle: inputs applied at a falling edge, outputs settled at the next one
   task automatic tick(input logic b, input logic en, input logic clr);
      rx_bit = b; bit_en = en; flag_clr = clr;
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic prbs(input logic flip, input logic clr = 1'b0);
      logic b;
      b = gen[14] ^ gen[13];
      gen = {gen[13:0], b};
      if (e_sync) begin
         e_bits = e_bits + 1;
         if (flip && e_errs < 15) e_errs = e_errs + 1;
      end
      tick(b ^ flip, 1'b1, clr);
   endtask

   task automatic clean(input int n);
      for (int i = 0; i < n; i++) prbs(1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      check("R4 reset bit_count", int'(bit_count), 0);
      check("R4 reset err_count", int'(err_count), 0);
      check("R6 reset flags", int'(flags), 0);
      check("R2 reset in_sync", int'(in_sync), 0);

      // R2: lock on a pseudorandom stream
      clean(31);
      check("R2 no lock within 31 bits", int'(in_sync), 0);
      check("R4 no count out of lock", int'(bit_count), 0);
      clean(16);
      check("R1 R2 lock on prbs", int'(in_sync), 1);
      check("R6 lock-change flag", int'(flags[2]), 1);
      check("R8 irq masked", int'(irq), 0);
      int_en = 3'b100; #1;
      check("R8 irq lock-change", int'(irq), 1);
      e_sync = 1'b1;
      e_bits = int'(bit_count);
      tick(1'b0, 1'b0, 1'b1);
      check("R7 clear", int'(flags), 0);

      clean(100);
      check("R4 bits counted", int'(bit_count), e_bits);
      check("R4 no errors", int'(err_count), 0);

      for (int i = 0; i < 10; i++) tick(i[0], 1'b0, 1'b0);
      check("R4 bit_en low ignored bits", int'(bit_count), e_bits);
      check("R4 bit_en low ignored errs", int'(err_count), 0);

      prbs(1'b1); clean(30);
      check("R9 single flip one error", int'(err_count), e_errs);
      check("R6 error flag", int'(flags[1]), 1);
      int_en = 3'b010; #1;
      check("R8 irq error enabled", int'(irq), 1);
      int_en = 3'b101; #1;
      check("R8 irq error masked", int'(irq), 0);
      tick(1'b0, 1'b0, 1'b1);

      prbs(1'b1, 1'b1);
      check("R7 set wins over clear", int'(flags[1]), 1);
      check("R7 error count same cycle", int'(err_count), 2);
      tick(1'b0, 1'b0, 1'b1);
      clean(70);

      for (int i = 0; i < 8; i++) begin prbs(1'b1); clean(12); end
      check("R3 spaced errors keep lock", int'(in_sync), 1);
      check("R4 error total", int'(err_count), 10);
      check("R6 no lock change", int'(flags[2]), 0);
      clean(70);
      tick(1'b0, 1'b0, 1'b1);

      for (int i = 0; i < 5; i++) begin prbs(1'b1); clean(11); end
      check("R3 five close errors keep lock", int'(in_sync), 1);
      check("R5 err at max no flag yet", int'(flags[0]), 0);
      check("R5 err count 15", int'(err_count), 15);
      prbs(1'b1);
      e_sync = 1'b0;
      check("R3 sixth close error drops lock", int'(in_sync), 0);
      check("R5 err saturates", int'(err_count), 15);
      check("R5 err overflow flag", int'(flags[0]), 1);
      check("R6 lock loss flagged", int'(flags[2]), 1);
      check("R4 bits through loss", int'(bit_count), e_bits);

      clean(31);
      check("R2 relock not before 32", int'(in_sync), 0);
      check("R4 frozen out of lock", int'(bit_count), e_bits);
      clean(1);
      check("R2 relock at 32", int'(in_sync), 1);
      check("R4 relock bit uncounted", int'(bit_count), e_bits);
      e_sync = 1'b1;
      tick(1'b0, 1'b0, 1'b1);

      clean(int'(BIT_MAX) - int'(bit_count));
      check("R5 bit count at max", int'(bit_count), int'(BIT_MAX));
      check("R5 no overflow at max", int'(flags[0]), 0);
      clean(1);
      check("R5 bit count saturates", int'(bit_count), int'(BIT_MAX));
      check("R5 bit overflow flag", int'(flags[0]), 1);

      // R1: every repeat length code
      e_sync = 1'b0;
      pat_sel = 1'b0;
      for (int c = 0; c < 16; c++) begin
         int per, base, k;
         per = 17 + c;
         len_code = 4'(c);
         do_reset();
         k = 0;
         for (int i = 0; i < per + 32; i++) begin tick(REP_WORD[k], 1'b1, 1'b0); k = (k + 1) % per; end
         check($sformatf("R1 lock period %0d", per), int'(in_sync), 1);
         base = int'(bit_count);
         for (int i = 0; i < 40; i++) begin tick(REP_WORD[k], 1'b1, 1'b0); k = (k + 1) % per; end
         check($sformatf("R1 count period %0d", per), int'(bit_count), base + 40);
         check($sformatf("R1 clean period %0d", per), int'(err_count), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule